// File: doc/BRIEF.md
# Performance Monitor User-Access Gate

This block decides, for each access to a performance-monitor register, whether the access may go ahead or must trap. The decision also gives the privilege level the trap goes to. The block holds one small control register, the user-enable register. Its bits let software running at the lowest privilege level reach specific monitor register classes, in specific directions. The counters and the events they count live elsewhere. This block only judges access.

Each request arrives as a one-cycle strobe and carries:
- the current privilege level (0 to 3),
- a write flag,
- a register-class code,
- write data, used only for the user-enable register.

Two side inputs shape the decision:
- an architecture-extension flag, which enables the per-class overrides and the wider user-enable register;
- a hypervisor trap control bit.

The decision is formed combinationally from the request fields. It is registered, so it appears on the response outputs exactly one cycle after the strobe. The same response carries the user-enable value as it stood before the request.

Top module: `pmu_access_gate`

## Requirements
- R1: After synchronous reset the user-enable register is zero and `rsp_valid` is low.
- R2: A permitted write to the user-enable register (class code 5) stores only data bit 0 when `arch_ext` is low, and stores data bits 3:0 when `arch_ext` is high; the other stored bits become zero.
- R3: At level 0, with no override in effect, an access to any class other than 5 traps to level 1 when user-enable bit 0 is clear. Class codes: 0 general, 1 software increment, 2 counter select, 3 cycle counter, 4 event counter; codes 6 and 7 behave as general.
- R4: With `arch_ext` high at level 0, user-enable bit 1 permits writes to class 1 even when bit 0 is clear. Reads of class 1 get no such override.
- R5: With `arch_ext` high at level 0, user-enable bit 2 permits reads of class 3. Writes of class 3 get no such override.
- R6: With `arch_ext` high at level 0, user-enable bit 3 permits reads of class 4 (but not writes) and permits both reads and writes of class 2.
- R7: Precedence and the hypervisor trap:
  - An override that applies permits the access even when `hyp_trap_pmu` is high.
  - Otherwise, at level 0 the bit-0 trap to level 1 takes priority.
  - Otherwise, a request at level 0 or 1 traps to level 2 when `hyp_trap_pmu` is high.
- R8: The user-enable register (class 5) behaves as follows:
  - It can be read at any level; `rsp_rdata` returns the value held before the request.
  - A write at level 0 traps to level 1 and leaves the value unchanged.
  - Writes at level 1 are subject to the hypervisor trap, and a trapped write changes nothing.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_permit` and `rsp_trap_el` give the decision for that request; `rsp_trap_el` is 0 when the access is permitted.
- R10: Requests at level 2 or 3 are always permitted.
- R11: With `arch_ext` low, user-enable bits 1 to 3 grant nothing, even if they were stored while `arch_ext` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_el | input | 2 | Current privilege level |
| req_write | input | 1 | 1 = write, 0 = read |
| req_class | input | 3 | Register class code |
| req_wdata | input | 4 | Write data for the user-enable register |
| arch_ext | input | 1 | Architecture-extension flag |
| hyp_trap_pmu | input | 1 | Hypervisor trap control for monitor accesses |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_permit | output | 1 | 1 = access permitted |
| rsp_trap_el | output | 2 | Trap target level, 0 when permitted |
| rsp_rdata | output | 4 | User-enable value before the request |

## Verification
Two rules can claim the same request:
- A per-class override and the hypervisor trap. The bench raises `hyp_trap_pmu` while issuing level-0 accesses that an override allows, and judges them permitted.
- The level-0 bit-0 trap and the hypervisor trap. With bit 0 clear and the hypervisor bit set, the bench expects the trap to go to level 1, not level 2.

A write to the user-enable register followed immediately by an access is also checked. That access must be judged against the newly stored value, and a hypervisor-trapped write must leave the register untouched. Each of these cases is driven on purpose, and then mixed in a long pseudo-random run. A behavioural model is compared against the outputs on every cycle.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;
  localparam int EL_W  = 2;
  localparam int CLS_W = 3;
  localparam int EN_W  = 4;

  // register class codes
  localparam logic [CLS_W-1:0] CLS_GENERAL = 3'd0;
  localparam logic [CLS_W-1:0] CLS_SWINC   = 3'd1;
  localparam logic [CLS_W-1:0] CLS_SELECT  = 3'd2;
  localparam logic [CLS_W-1:0] CLS_CYCLE   = 3'd3;
  localparam logic [CLS_W-1:0] CLS_EVENT   = 3'd4;
  localparam logic [CLS_W-1:0] CLS_UEN     = 3'd5;

  // user-enable bit positions
  localparam int UEN_ALL   = 0;
  localparam int UEN_SWINC = 1;
  localparam int UEN_CYC   = 2;
  localparam int UEN_EVT   = 3;

  localparam logic [EL_W-1:0] EL_USER = 2'd0;
  localparam logic [EL_W-1:0] EL_KERN = 2'd1;
  localparam logic [EL_W-1:0] EL_HYP  = 2'd2;
endpackage

// File: rtl/pmu_gate_uen_reg.sv
module pmu_gate_uen_reg
  import pmu_gate_pkg::*;
#(
  parameter int W = EN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         arch_ext,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  logic [W-1:0] masked;

  // bit 0 always writable, upper bits only with the extension
  generate
    for (genvar i = 0; i < W; i++) begin : g_mask
      if (i == 0) begin : g_base
        assign masked[i] = wdata[i];
      end else begin : g_ext
        assign masked[i] = wdata[i] & arch_ext;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= masked;
  end

  p_base_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !arch_ext) |=> (en_q[W-1:1] == '0));
  p_hold_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/pmu_gate_decide.sv
module pmu_gate_decide
  import pmu_gate_pkg::*;
(
  input  logic [EL_W-1:0]  el,
  input  logic             wr,
  input  logic [CLS_W-1:0] cls,
  input  logic [EN_W-1:0]  en,
  input  logic             arch_ext,
  input  logic             hyp_trap,
  output logic             permit,
  output logic [EL_W-1:0]  trap_el,
  output logic             uen_store
);
  logic at_user;
  logic below_hyp;
  logic ovr;

  assign at_user   = (el == EL_USER);
  assign below_hyp = (el < EL_HYP);

  // per-class user overrides, extension only
  always_comb begin
    ovr = 1'b0;
    if (arch_ext && at_user) begin
      case (cls)
        CLS_SWINC:  ovr = en[UEN_SWINC] & wr;
        CLS_SELECT: ovr = en[UEN_EVT];
        CLS_CYCLE:  ovr = en[UEN_CYC] & ~wr;
        CLS_EVENT:  ovr = en[UEN_EVT] & ~wr;
        default:    ovr = 1'b0;
      endcase
    end
  end

  always_comb begin
    permit  = 1'b1;
    trap_el = '0;
    if (cls == CLS_UEN) begin
      if (at_user && wr) begin
        permit  = 1'b0;
        trap_el = EL_KERN;
      end else if (below_hyp && hyp_trap) begin
        permit  = 1'b0;
        trap_el = EL_HYP;
      end
    end else if (!ovr) begin
      if (at_user && !en[UEN_ALL]) begin
        permit  = 1'b0;
        trap_el = EL_KERN;
      end else if (below_hyp && hyp_trap) begin
        permit  = 1'b0;
        trap_el = EL_HYP;
      end
    end
  end

  assign uen_store = (cls == CLS_UEN) && wr && permit;
endmodule

// File: rtl/pmu_gate_rsp.sv
module pmu_gate_rsp
  import pmu_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            permit,
  input  logic [EL_W-1:0] trap_el,
  input  logic [EN_W-1:0] rdata,
  output logic            rsp_valid,
  output logic            rsp_permit,
  output logic [EL_W-1:0] rsp_trap_el,
  output logic [EN_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_permit  <= 1'b0;
      rsp_trap_el <= '0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_permit  <= permit;
        rsp_trap_el <= trap_el;
        rsp_rdata   <= rdata;
      end
    end
  end
endmodule

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
  import pmu_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [EL_W-1:0]  req_el,
  input  logic             req_write,
  input  logic [CLS_W-1:0] req_class,
  input  logic [EN_W-1:0]  req_wdata,
  input  logic             arch_ext,
  input  logic             hyp_trap_pmu,
  output logic             rsp_valid,
  output logic             rsp_permit,
  output logic [EL_W-1:0]  rsp_trap_el,
  output logic [EN_W-1:0]  rsp_rdata
);
  logic [EN_W-1:0] en_q;
  logic            permit;
  logic [EL_W-1:0] trap_el;
  logic            uen_store;

  pmu_gate_decide u_decide (
    .el(req_el), .wr(req_write), .cls(req_class), .en(en_q),
    .arch_ext(arch_ext), .hyp_trap(hyp_trap_pmu),
    .permit(permit), .trap_el(trap_el), .uen_store(uen_store)
  );

  pmu_gate_uen_reg #(.W(EN_W)) u_uen (
    .clk(clk), .rst(rst), .wr_en(req_valid && uen_store),
    .arch_ext(arch_ext), .wdata(req_wdata), .en_q(en_q)
  );

  pmu_gate_rsp u_rsp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .permit(permit),
    .trap_el(trap_el), .rdata(en_q),
    .rsp_valid(rsp_valid), .rsp_permit(rsp_permit),
    .rsp_trap_el(rsp_trap_el), .rsp_rdata(rsp_rdata)
  );

  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_high_el_permit_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_el >= EL_HYP) |=> (rsp_permit && rsp_trap_el == '0));
  p_user_uen_write_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_el == EL_USER && req_class == CLS_UEN && req_write)
      |=> (!rsp_permit && rsp_trap_el == EL_KERN));
  p_trap_has_target_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_permit) |-> (rsp_trap_el == EL_KERN || rsp_trap_el == EL_HYP));
endmodule

// File: tb/sim_pmu_access_gate.sv
module sim_pmu_access_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_el = '0;
  logic       req_write = 1'b0;
  logic [2:0] req_class = '0;
  logic [3:0] req_wdata = '0;
  logic       arch_ext = 1'b0;
  logic       hyp_trap_pmu = 1'b0;
  logic       rsp_valid, rsp_permit;
  logic [1:0] rsp_trap_el;
  logic [3:0] rsp_rdata;

  always #10 clk = ~clk;  // 50 MHz

  pmu_access_gate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_el(req_el),
    .req_write(req_write), .req_class(req_class), .req_wdata(req_wdata),
    .arch_ext(arch_ext), .hyp_trap_pmu(hyp_trap_pmu),
    .rsp_valid(rsp_valid), .rsp_permit(rsp_permit),
    .rsp_trap_el(rsp_trap_el), .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0, n_fail = 0;
  int m_en = 0;
  bit exp_v = 0, exp_p = 0, exp_dchk = 0;
  int exp_t = 0, exp_d = 0;
  string exp_tag = "R1";
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(exp_tag, "rsp_valid", int'(rsp_valid), int'(exp_v));
    if (exp_v) begin
      chk(exp_tag, "rsp_permit", int'(rsp_permit), int'(exp_p));
      chk(exp_tag, "rsp_trap_el", int'(rsp_trap_el), exp_t);
      if (exp_dchk) chk(exp_tag, "rsp_rdata", int'(rsp_rdata), exp_d);
    end
  endtask

  // behavioural reference: rules straight from the requirement list
  task automatic model(int el, bit wr, int cls, int wd, bit ax, bit hy);
    bit ok_ovr = 0;
    exp_p = 1; exp_t = 0; exp_d = m_en;
    exp_dchk = (cls == 5) && !wr;
    if (ax && el == 0) begin
      if (cls == 1 && wr && m_en[1]) ok_ovr = 1;
      if (cls == 3 && !wr && m_en[2]) ok_ovr = 1;
      if (cls == 4 && !wr && m_en[3]) ok_ovr = 1;
      if (cls == 2 && m_en[3]) ok_ovr = 1;
    end
    if (cls == 5) begin
      if (el == 0 && wr) begin exp_p = 0; exp_t = 1; end
      else if (el < 2 && hy) begin exp_p = 0; exp_t = 2; end
    end else if (!ok_ovr) begin
      if (el == 0 && !m_en[0]) begin exp_p = 0; exp_t = 1; end
      else if (el < 2 && hy) begin exp_p = 0; exp_t = 2; end
    end
    if (cls == 5 && wr && exp_p) m_en = ax ? (wd & 15) : (wd & 1);
  endtask

  task automatic step(string tag, int el, bit wr, int cls, int wd, bit ax, bit hy);
    @(negedge clk);
    compare();
    req_valid = 1; req_el = 2'(el); req_write = wr; req_class = 3'(cls);
    req_wdata = 4'(wd); arch_ext = ax; hyp_trap_pmu = hy;
    exp_tag = tag; exp_v = 1;
    model(el, wr, cls, wd, ax, hy);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    compare();
    req_valid = 0; exp_v = 0; exp_tag = tag;
  endtask

  task automatic set_en(int v);
    step("R2", 1, 1, 5, v, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst = 0;
    // R1: enable register reads zero, user general access traps
    step("R1", 1, 0, 5, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 1, 0);
    // R8: user write rejected, value kept
    step("R8", 0, 1, 5, 15, 1, 0);
    step("R8", 1, 0, 5, 0, 1, 0);
    step("R8", 0, 0, 5, 0, 1, 0);
    // R2: masking by the extension flag
    step("R2", 1, 1, 5, 15, 0, 0);
    step("R2", 1, 0, 5, 0, 0, 0);
    step("R2", 1, 1, 5, 15, 1, 0);
    step("R2", 1, 0, 5, 0, 1, 0);
    // R3: bit 0 gating
    set_en(1);
    step("R3", 0, 0, 0, 0, 1, 0);
    step("R3", 0, 1, 7, 0, 0, 0);
    set_en(0);
    step("R3", 0, 0, 0, 0, 1, 0);
    step("R3", 0, 1, 6, 0, 1, 0);
    // R4: software increment
    set_en(2);
    step("R4", 0, 1, 1, 0, 1, 0);
    step("R4", 0, 0, 1, 0, 1, 0);
    // R5: cycle counter
    set_en(4);
    step("R5", 0, 0, 3, 0, 1, 0);
    step("R5", 0, 1, 3, 0, 1, 0);
    // R6: event counter and select
    set_en(8);
    step("R6", 0, 0, 4, 0, 1, 0);
    step("R6", 0, 1, 4, 0, 1, 0);
    step("R6", 0, 0, 2, 0, 1, 0);
    step("R6", 0, 1, 2, 0, 1, 0);
    step("R6", 0, 0, 0, 0, 1, 0);
    // R11: bits stored earlier, extension now off
    set_en(14);
    step("R11", 0, 1, 1, 0, 0, 0);
    step("R11", 0, 0, 3, 0, 0, 0);
    step("R11", 0, 0, 4, 0, 0, 0);
    // R7: precedence against the hypervisor trap
    step("R7", 0, 0, 3, 0, 1, 1);
    step("R7", 0, 0, 0, 0, 1, 1);
    step("R7", 1, 0, 0, 0, 1, 1);
    set_en(1);
    step("R7", 0, 0, 0, 0, 1, 1);
    step("R8", 1, 1, 5, 15, 1, 1);
    step("R8", 2, 0, 5, 0, 1, 1);
    // R10: high levels always pass
    set_en(0);
    step("R10", 2, 1, 0, 0, 1, 1);
    step("R10", 3, 0, 3, 0, 0, 1);
    step("R10", 2, 1, 5, 9, 1, 1);
    step("R10", 3, 0, 5, 0, 1, 1);
    // R9: idle gaps and back-to-back
    idle("R9");
    idle("R9");
    step("R9", 1, 0, 5, 0, 1, 0);
    idle("R9");
    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 4) == 0) idle("R9 mixed");
      else step("R7 mixed", $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                $urandom_range(0, 7), $urandom_range(0, 15),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
    end
    idle("R9");
    idle("R9");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule